// File: doc/BRIEF.md
# Prioritised Interrupt Vector Selector

This block sits beside a small processor's sequencer and decides, at each instruction boundary, whether an interrupt is taken. It has three sources. A maskable request is active low and level-sensitive, and the I mask bit can block it. A non-maskable request is active low and is latched on its falling edge. A software-interrupt strobe is held pending until it is serviced. When a source wins, the block does four things:

- It raises a one-cycle take pulse.
- It reports which source won.
- It presents the high-byte and low-byte addresses of that source's vector pair at the top of memory.
- It drives a two-bit bus-status code that marks the acknowledge window.

The sequencer treats the take pulse as its cue to set I, to push the registers at the stack pointer, and to read the vector. Those steps are outside this block.

The vector pairs start at a parameterised base address, 0xFFF8 by default. The maskable source uses base+0 and base+1. The software interrupt uses base+2 and base+3. The non-maskable source uses base+4 and base+5. The package also defines the bus-status encodings for sync acknowledge and halt acknowledge. Only normal (00) and interrupt acknowledge (01) are driven here.

Top module: `irq_vector_select`

## Requirements
- R1: After reset, take_int is 0, src_sel is 00 and bus_status is 00.
- R2: At a boundary edge with irq_req_n low and mask_i low, the block takes the maskable source. In the next cycle, take_int is 1, src_sel is 01, vec_hi_addr is 0xFFF8 and vec_lo_addr is 0xFFF9.
- R3: When mask_i is 1, a low irq_req_n is ignored. No take pulse occurs and bus_status stays 00.
- R4: A falling edge on nmi_req_n is taken at a later boundary whatever mask_i is. In that case src_sel is 11, vec_hi_addr is 0xFFFC and vec_lo_addr is 0xFFFD.
- R5: One falling edge on nmi_req_n is serviced exactly once, even if the input stays low across several later boundaries.
- R6: A high cycle on swi_strobe is held pending until it is taken. In that case src_sel is 10, vec_hi_addr is 0xFFFA and vec_lo_addr is 0xFFFB.
- R7: When several sources are eligible, the non-maskable source wins first, then the software interrupt, then the maskable source. A pending source that loses is still served at a later boundary.
- R8: No interrupt is taken while instr_boundary is low. A pending non-maskable edge waits for the next boundary. An edge that arrives on the same clock edge as a boundary is taken at the following boundary, not that one.
- R9: bus_status is 01 for ACK_LEN cycles, starting with the cycle in which take_int is high, and 00 otherwise. The block takes no interrupt while this window is open.
- R10: take_int is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_n | input | 1 | Maskable request, active low, level-sensitive |
| nmi_req_n | input | 1 | Non-maskable request, active low, falling-edge latched |
| swi_strobe | input | 1 | Software-interrupt request, one or more high cycles |
| mask_i | input | 1 | I mask bit; 1 blocks the maskable request |
| instr_boundary | input | 1 | High on the clock edge where an interrupt may be taken |
| take_int | output | 1 | One-cycle pulse: interrupt accepted |
| src_sel | output | 2 | Winning source: 01 maskable, 10 software, 11 non-maskable |
| vec_hi_addr | output | ADDR_W | Address of the vector high byte |
| vec_lo_addr | output | ADDR_W | Address of the vector low byte |
| bus_status | output | 2 | 00 normal, 01 interrupt acknowledge (10 sync, 11 halt reserved) |

## Verification
The bench drives a non-maskable edge on the same clock edge as a boundary. A design that reads the raw edge instead of the latched state would take it one boundary early.

It holds the non-maskable input low across several boundaries. A level-sensitive design would take the interrupt again and again.

It raises all three sources together and expects them to be served in order, one at each of three boundaries. A design with the wrong priority, or one that drops a losing pending source, returns the wrong vectors or too few takes.

It also holds the boundary high for consecutive cycles. A design that ignored the acknowledge window would produce a two-cycle take pulse.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_IRQ  = 2'b01,
      SRC_SWI  = 2'b10,
      SRC_NMI  = 2'b11
   } src_e;

   localparam logic [1:0] BS_NORMAL   = 2'b00;
   localparam logic [1:0] BS_INT_ACK  = 2'b01;
   localparam logic [1:0] BS_SYNC_ACK = 2'b10;
   localparam logic [1:0] BS_HALT_ACK = 2'b11;

   // offset of each source's high-byte vector from the base
   function automatic int unsigned vec_offset(src_e s);
      case (s)
         SRC_SWI: return 2;
         SRC_NMI: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/req_capture.sv
module req_capture #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic clear,
   output logic pend
);

   logic set_now;

   generate
      if (FALL_EDGE) begin : g_fall
         logic sig_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sig_q <= 1'b1;
            else        sig_q <= sig;
         end
         assign set_now = sig_q & ~sig;
      end else begin : g_level
         assign set_now = sig;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= set_now | (pend & ~clear);
   end

   AST_PEND_SERVED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && clear && !set_now) |=> !pend); // R5

endmodule

// File: rtl/src_arbiter.sv
module src_arbiter
   import irq_sel_pkg::*;
(
   input  logic nmi_pend,
   input  logic swi_pend,
   input  logic irq_ok,
   output src_e winner
);

   always_comb begin
      if (nmi_pend)      winner = SRC_NMI;
      else if (swi_pend) winner = SRC_SWI;
      else if (irq_ok)   winner = SRC_IRQ;
      else               winner = SRC_NONE;
   end

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
   import irq_sel_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF8
) (
   input  src_e              src,
   output logic [ADDR_W-1:0] hi_addr,
   output logic [ADDR_W-1:0] lo_addr
);

   always_comb begin
      hi_addr = VEC_BASE + ADDR_W'(vec_offset(src));
      lo_addr = hi_addr + ADDR_W'(1);
   end

endmodule

// File: rtl/irq_vector_select.sv
module irq_vector_select
   import irq_sel_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF8,
   parameter int unsigned ACK_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req_n,
   input  logic              nmi_req_n,
   input  logic              swi_strobe,
   input  logic              mask_i,
   input  logic              instr_boundary,
   output logic              take_int,
   output logic [1:0]        src_sel,
   output logic [ADDR_W-1:0] vec_hi_addr,
   output logic [ADDR_W-1:0] vec_lo_addr,
   output logic [1:0]        bus_status
);

   localparam int unsigned CNT_W = $clog2(ACK_LEN + 1);

   generate
      if (ADDR_W < 4) begin : g_bad_width
         $error("ADDR_W must be at least 4");
      end
      if (ACK_LEN < 1) begin : g_bad_ack
         $error("ACK_LEN must be at least 1");
      end
      if ((VEC_BASE % 8) != 0) begin : g_bad_base
         $error("VEC_BASE must be aligned to 8");
      end
   endgenerate

   logic             nmi_pend, swi_pend, irq_ok, ack_idle, take_now;
   src_e             winner, src_q;
   logic [ADDR_W-1:0] hi_nxt, lo_nxt;
   logic [CNT_W-1:0] ack_cnt;

   assign irq_ok   = ~irq_req_n & ~mask_i;
   assign ack_idle = (ack_cnt == '0);
   assign take_now = instr_boundary & ack_idle & (winner != SRC_NONE);

   req_capture #(.FALL_EDGE(1'b1)) u_nmi_cap (
      .clk(clk), .rst_n(rst_n), .sig(nmi_req_n),
      .clear(take_now && winner == SRC_NMI), .pend(nmi_pend)
   );

   req_capture #(.FALL_EDGE(1'b0)) u_swi_cap (
      .clk(clk), .rst_n(rst_n), .sig(swi_strobe),
      .clear(take_now && winner == SRC_SWI), .pend(swi_pend)
   );

   src_arbiter u_arb (
      .nmi_pend(nmi_pend), .swi_pend(swi_pend), .irq_ok(irq_ok), .winner(winner)
   );

   vec_addr_gen #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
      .src(winner), .hi_addr(hi_nxt), .lo_addr(lo_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_int    <= 1'b0;
         src_q       <= SRC_NONE;
         vec_hi_addr <= '0;
         vec_lo_addr <= '0;
         ack_cnt     <= '0;
      end else begin
         take_int <= take_now;
         if (take_now) begin
            src_q       <= winner;
            vec_hi_addr <= hi_nxt;
            vec_lo_addr <= lo_nxt;
            ack_cnt     <= CNT_W'(ACK_LEN);
         end else if (!ack_idle) begin
            ack_cnt <= ack_cnt - CNT_W'(1);
         end
      end
   end

   assign src_sel    = src_q;
   assign bus_status = ack_idle ? BS_NORMAL : BS_INT_ACK;

   AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> $past(instr_boundary)); // R8
   AST_IRQ_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_int && src_sel == SRC_IRQ) |-> $past(!mask_i && !irq_req_n)); // R3
   AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_int && src_sel != SRC_NMI) |-> !$past(nmi_pend)); // R7
   AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |=> !take_int); // R10
   AST_ACK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> bus_status == BS_INT_ACK); // R9

endmodule

// File: tb/irq_vector_select_test.sv
module irq_vector_select_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req_n = 1'b1, nmi_req_n = 1'b1, swi_strobe = 1'b0;
   logic        mask_i = 1'b1, instr_boundary = 1'b0;
   logic        take_int;
   logic [1:0]  src_sel, bus_status;
   logic [15:0] vec_hi_addr, vec_lo_addr;

   int checks = 0;
   int fails  = 0;
   logic [33:0] expq[$];   // {src, hi, lo}

   always #2.5 clk = ~clk;

   irq_vector_select uut (
      .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .nmi_req_n(nmi_req_n),
      .swi_strobe(swi_strobe), .mask_i(mask_i), .instr_boundary(instr_boundary),
      .take_int(take_int), .src_sel(src_sel), .vec_hi_addr(vec_hi_addr),
      .vec_lo_addr(vec_lo_addr), .bus_status(bus_status)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected vector pair from the requirements
   task automatic expect_take(input logic [1:0] src);
      logic [15:0] hi;
      case (src)
         2'b01: hi = 16'hFFF8;
         2'b10: hi = 16'hFFFA;
         default: hi = 16'hFFFC;
      endcase
      expq.push_back({src, hi, hi + 16'd1});
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && take_int) begin
         if (expq.size() == 0) begin
            check(1'b0, "R3/R5/R8", "unexpected take src", src_sel, 0);
         end else begin
            logic [33:0] e;
            e = expq.pop_front();
            check(src_sel == e[33:32], "R2/R4/R6/R7", "src_sel", src_sel, e[33:32]);
            check(vec_hi_addr == e[31:16], "R2/R4/R6", "vec_hi_addr", vec_hi_addr, e[31:16]);
            check(vec_lo_addr == e[15:0], "R2/R4/R6", "vec_lo_addr", vec_lo_addr, e[15:0]);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic boundary(input logic exp_take, input string req);
      instr_boundary = 1'b1;
      @(negedge clk);
      instr_boundary = 1'b0;
      check(take_int == exp_take, req, "take_int", take_int, exp_take);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      idle(3);
      // R1 reset state
      check(take_int == 1'b0, "R1", "take_int", take_int, 0);
      check(src_sel == 2'b00, "R1", "src_sel", src_sel, 0);
      check(bus_status == 2'b00, "R1", "bus_status", bus_status, 0);
      rst_n = 1'b1;
      idle(2);

      // R2 maskable request accepted; R9 acknowledge window
      irq_req_n = 1'b0; mask_i = 1'b0;
      expect_take(2'b01);
      boundary(1'b1, "R2");
      check(bus_status == 2'b01, "R9", "bus_status ack cycle 1", bus_status, 1);
      irq_req_n = 1'b1;
      idle(1);
      check(bus_status == 2'b01, "R9", "bus_status ack cycle 2", bus_status, 1);
      idle(1);
      check(bus_status == 2'b00, "R9", "bus_status after ack", bus_status, 0);
      idle(2);

      // R3 masked request ignored
      irq_req_n = 1'b0; mask_i = 1'b1;
      boundary(1'b0, "R3");
      check(bus_status == 2'b00, "R3", "bus_status", bus_status, 0);
      irq_req_n = 1'b1; mask_i = 1'b0;
      boundary(1'b0, "R2");
      idle(2);

      // R4 NMI pulse taken with I=1
      mask_i = 1'b1;
      nmi_req_n = 1'b0; idle(1); nmi_req_n = 1'b1; idle(1);
      expect_take(2'b11);
      boundary(1'b1, "R4");
      idle(4);
      boundary(1'b0, "R5");
      idle(4);

      // R5 NMI held low across boundaries: one take only
      nmi_req_n = 1'b0; idle(2);
      expect_take(2'b11);
      boundary(1'b1, "R5");
      idle(4); boundary(1'b0, "R5");
      idle(4); boundary(1'b0, "R5");
      nmi_req_n = 1'b1; idle(3);

      // R8 pending NMI waits for boundary
      nmi_req_n = 1'b0; idle(1); nmi_req_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         idle(1);
         check(take_int == 1'b0, "R8", "take without boundary", take_int, 0);
      end
      expect_take(2'b11);
      boundary(1'b1, "R8");
      idle(4);

      // R8 edge coincident with boundary waits one boundary
      nmi_req_n = 1'b0;
      boundary(1'b0, "R8");
      nmi_req_n = 1'b1;
      idle(2);
      expect_take(2'b11);
      boundary(1'b1, "R8");
      idle(4);

      // R6 software interrupt pending
      swi_strobe = 1'b1; idle(1); swi_strobe = 1'b0; idle(3);
      expect_take(2'b10);
      boundary(1'b1, "R6");
      idle(4);

      // R7 priority NMI > SWI > IRQ
      mask_i = 1'b0; irq_req_n = 1'b0; nmi_req_n = 1'b0; swi_strobe = 1'b1;
      idle(1);
      swi_strobe = 1'b0; nmi_req_n = 1'b1;
      expect_take(2'b11); boundary(1'b1, "R7"); idle(4);
      expect_take(2'b10); boundary(1'b1, "R7"); idle(4);
      expect_take(2'b01); boundary(1'b1, "R7"); idle(4);

      // R10 / R9 boundary held two edges: one take, single-cycle pulse
      expect_take(2'b01);
      instr_boundary = 1'b1;
      @(negedge clk);
      check(take_int == 1'b1, "R10", "take_int first", take_int, 1);
      @(negedge clk);
      instr_boundary = 1'b0;
      check(take_int == 1'b0, "R10", "take_int second", take_int, 0);
      check(bus_status == 2'b01, "R9", "bus_status in window", bus_status, 1);
      irq_req_n = 1'b1;
      idle(4);

      check(expq.size() == 0, "R2/R4/R6/R7", "missing takes", expq.size(), 0);
      summary();
   end

endmodule